// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

This block fetches the processor's boot-time configuration from an external serial source once the supply is reported good. It divides the system clock down to a slow mode clock, samples one data bit per mode-clock period and collects the bits into a mode word. Until the last bit has arrived, the load-done output stays low, and the core is held in reset through it.

From the finished word the block derives three settings. The first is the effective byte order, taken either from a live external pin or from a bit in the word. The second is the two-bit output-drive timing code. The third is a configuration-error flag, raised when the two high-frequency enable bits are not both set.

The serial stream is a fixed-rate source and cannot be paused, so the input side has no valid/ready handshake. The block applies no back-pressure: a bit is taken at each rising mode-clock edge whether or not the source is ready. The results are plain level outputs that stay valid for as long as load-done is high.

Top module: `boot_mode_loader`

## Requirements
- R1: `mode_clk` has a period of 2**DIV_LOG2 system clocks (256 by default) and is high for half of each period. It is low in the cycle after `power_ok` is seen low.
- R2: A load starts when `power_ok` goes high. The first bit is captured at the first rising edge of `mode_clk`, which is the 2**(DIV_LOG2-1)-th clock edge with `power_ok` high. `load_done` rises at that edge plus (NBITS-1) mode-clock periods.
- R3: The stream is NBITS bits long (256 by default, at least 34), sent least significant first. The first bit received lands in `mode_word[0]`, the last in `mode_word[NBITS-1]`.
- R4: `load_done` stays low until the last bit is captured, then stays high while `power_ok` stays high. `mode_word` reads zero before `load_done`. After `load_done`, further `mode_in` activity leaves `mode_word` unchanged.
- R5: Whenever `power_ok` is low, the bit counter, the mode word and `load_done` clear. The next assertion of `power_ok` starts a complete new load from bit 0.
- R6: After `load_done`, `big_endian` follows the `big_endian_pin` input when `mode_word[8]` is 0. When `mode_word[8]` is 1, `big_endian` equals `mode_word[7]`. Before `load_done`, `big_endian` is 0.
- R7: After `load_done`, `drive_sel` equals `mode_word[14:13]`, where 2'b10 is the fastest output timing and 2'b01 the slowest. Before `load_done`, `drive_sel` is 0.
- R8: `cfg_err` is high exactly when `load_done` is high and `mode_word[20]` and `mode_word[33]` are not both 1.
- R9: Driving `rst_n` low clears every register asynchronously, so `mode_clk`, `load_done` and all decoded outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_ok | input | 1 | Supply-good indication; starts the load when high, aborts it when low |
| mode_in | input | 1 | Serial configuration data |
| big_endian_pin | input | 1 | External byte-order select |
| mode_clk | output | 1 | Divided mode clock for the serial source |
| load_done | output | 1 | High once the whole stream is captured; core reset release |
| mode_word | output | NBITS | Captured configuration word, zero until done |
| big_endian | output | 1 | Effective byte order |
| drive_sel | output | 2 | Output-drive timing code |
| cfg_err | output | 1 | High-frequency enable bits not both set |

## Verification
If the bit counter is off, `load_done` rises one or more mode-clock periods early or late, and that shows within the first load. A count that is not cleared on a supply drop shows on the reload that follows. If the shift direction or the field positions are wrong, the word and the decoded outputs at the `load_done` edge come out bit-reversed or shifted. A wrong divider shows in the `mode_clk` period and duty within two periods of the load starting. Captures that leak past the end of the stream show up as `mode_word` changing a few periods after `load_done`.

// File: rtl/bml_pkg.sv
package bml_pkg;
  // stored-word field positions the decoder relies on
  localparam int ENDIAN_SRC_BIT = 8;   // 0: pin decides, 1: stored value decides
  localparam int ENDIAN_VAL_BIT = 7;   // stored byte-order value
  localparam int DRIVE_LO_BIT   = 13;  // drive timing field [14:13]
  localparam int FREQ_EN_A_BIT  = 20;
  localparam int FREQ_EN_B_BIT  = 33;
  localparam int MIN_BITS       = FREQ_EN_B_BIT + 1;

  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_SLOW = 2'b01,
    DRV_FAST = 2'b10,
    DRV_RSVD = 2'b11
  } drive_t;
endpackage

// File: rtl/bml_clkdiv.sv
module bml_clkdiv #(
  parameter int DIV_LOG2 = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mode_clk,
  output logic sample_stb
);
  localparam int          CW   = DIV_LOG2;
  localparam logic [CW-1:0] HALF_M1 = CW'((1 << (DIV_LOG2 - 1)) - 1);

  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_cnt <= '0;
    else if (!run) div_cnt <= '0;
    else           div_cnt <= div_cnt + 1'b1;
  end

  // mode clock is the counter MSB; it rises on the edge the strobe marks
  assign mode_clk   = div_cnt[CW-1];
  assign sample_stb = run && (div_cnt == HALF_M1);
endmodule

// File: rtl/bml_shift.sv
module bml_shift #(
  parameter int NBITS = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             stb,
  input  logic             bit_in,
  output logic [NBITS-1:0] word,
  output logic             done
);
  localparam int              IDXW = $clog2(NBITS);
  localparam logic [IDXW-1:0] LAST = IDXW'(NBITS - 1);

  logic [IDXW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      idx  <= '0;
      done <= 1'b0;
    end else if (!run) begin
      word <= '0;
      idx  <= '0;
      done <= 1'b0;
    end else if (stb && !done) begin
      // enter at the top: after NBITS shifts the first bit sits at [0]
      word <= {bit_in, word[NBITS-1:1]};
      if (idx == LAST) done <= 1'b1;
      else             idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/bml_decode.sv
module bml_decode
  import bml_pkg::*;
#(
  parameter int NBITS = 256
) (
  input  logic [NBITS-1:0] word,
  input  logic             done,
  input  logic             pin_big,
  output logic [NBITS-1:0] mode_word,
  output logic             big_endian,
  output logic [1:0]       drive_sel,
  output logic             cfg_err
);
  drive_t drv;

  always_comb begin
    drv        = drive_t'(word[DRIVE_LO_BIT +: 2]);
    mode_word  = done ? word : '0;
    big_endian = done && (word[ENDIAN_SRC_BIT] ? word[ENDIAN_VAL_BIT] : pin_big);
    drive_sel  = done ? drv : DRV_NONE;
    cfg_err    = done && !(word[FREQ_EN_A_BIT] && word[FREQ_EN_B_BIT]);
  end
endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader #(
  parameter int NBITS    = 256,
  parameter int DIV_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             power_ok,
  input  logic             mode_in,
  input  logic             big_endian_pin,
  output logic             mode_clk,
  output logic             load_done,
  output logic [NBITS-1:0] mode_word,
  output logic             big_endian,
  output logic [1:0]       drive_sel,
  output logic             cfg_err
);
  logic             stb;
  logic [NBITS-1:0] raw_word;

  bml_clkdiv #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (power_ok),
    .mode_clk   (mode_clk),
    .sample_stb (stb)
  );

  bml_shift #(.NBITS(NBITS)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (power_ok),
    .stb    (stb),
    .bit_in (mode_in),
    .word   (raw_word),
    .done   (load_done)
  );

  bml_decode #(.NBITS(NBITS)) u_dec (
    .word       (raw_word),
    .done       (load_done),
    .pin_big    (big_endian_pin),
    .mode_word  (mode_word),
    .big_endian (big_endian),
    .drive_sel  (drive_sel),
    .cfg_err    (cfg_err)
  );
endmodule

// File: rtl/bml_checker.sv
module bml_checker #(
  parameter int NBITS = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             power_ok,
  input logic             mode_clk,
  input logic             load_done,
  input logic [NBITS-1:0] mode_word,
  input logic             big_endian,
  input logic [1:0]       drive_sel,
  input logic             cfg_err
);
  // R1
  mclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !power_ok |=> !mode_clk);

  // R1
  mclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_clk) |-> $past(power_ok));

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && power_ok) |=> (load_done || !power_ok));

  // R4
  word_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && power_ok) |=> $stable(mode_word));

  // R5
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !power_ok |=> (!load_done && mode_word == '0));

  // R6
  endian_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> !big_endian);

  // R7
  drive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> drive_sel == 2'b00);

  // R8
  err_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> load_done);
endmodule

bind boot_mode_loader bml_checker #(.NBITS(NBITS)) i_bml_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .power_ok  (power_ok),
  .mode_clk  (mode_clk),
  .load_done (load_done),
  .mode_word (mode_word),
  .big_endian(big_endian),
  .drive_sel (drive_sel),
  .cfg_err   (cfg_err)
);

// File: tb/test_boot_mode_loader.sv
module test_boot_mode_loader;
  localparam int NB  = 40;
  localparam int DL  = 8;
  localparam int PER = 1 << DL;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          power_ok = 1'b0;
  logic          mode_in = 1'b0;
  logic          big_endian_pin = 1'b0;
  logic          mode_clk, load_done, big_endian, cfg_err;
  logic [NB-1:0] mode_word;
  logic [1:0]    drive_sel;

  boot_mode_loader #(.NBITS(NB), .DIV_LOG2(DL)) i_boot_mode_loader (
    .clk(clk), .rst_n(rst_n), .power_ok(power_ok), .mode_in(mode_in),
    .big_endian_pin(big_endian_pin), .mode_clk(mode_clk), .load_done(load_done),
    .mode_word(mode_word), .big_endian(big_endian), .drive_sel(drive_sel),
    .cfg_err(cfg_err)
  );

  int checks = 0;
  int bad    = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // serial source: advances one bit after each rising mode clock
  logic [NB-1:0] rom = '0;
  int            ridx = 0;
  logic          prev_mclk = 1'b0;
  logic          junk = 1'b0;
  always @(negedge clk) begin
    if (!power_ok) ridx <= 0;
    else if (mode_clk && !prev_mclk) begin
      ridx <= ridx + 1;
      junk <= ~junk;
    end
    prev_mclk <= mode_clk;
  end
  always_comb mode_in = (ridx < NB) ? rom[ridx] : junk;

  // scoreboard
  logic [NB-1:0] exp_q[$];
  logic [NB-1:0] mon_e;
  logic          prev_done = 1'b0;
  always @(negedge clk) begin
    prev_done <= load_done;
    if (load_done && !prev_done) begin
      if (exp_q.size() == 0) check("R4 done without load", 1, 0);
      else begin
        mon_e = exp_q.pop_front();
        check("R3 word", 64'(mode_word), 64'(mon_e));
        check("R6 endian", 64'(big_endian),
              64'(mon_e[8] ? mon_e[7] : big_endian_pin));
        check("R7 drive", 64'(drive_sel), 64'(mon_e[14:13]));
        check("R8 cfg_err", 64'(cfg_err), 64'(!(mon_e[20] && mon_e[33])));
      end
    end
  end

  function automatic logic [NB-1:0] make_word(logic [NB-1:0] base, logic src,
      logic val, logic [1:0] drv, logic fa, logic fb);
    logic [NB-1:0] w = base;
    w[8] = src; w[7] = val; w[14:13] = drv; w[20] = fa; w[33] = fb;
    return w;
  endfunction

  task automatic full_load(logic [NB-1:0] w, logic pin);
    int n = 0;
    int r1 = -1, r2 = -1, f1 = -1;
    logic pm;
    rom = w;
    big_endian_pin = pin;
    exp_q.push_back(w);
    @(negedge clk);
    power_ok = 1'b1;
    pm = mode_clk;
    forever begin
      @(negedge clk);
      n++;
      if (mode_clk && !pm) begin
        if (r1 < 0) r1 = n; else if (r2 < 0) r2 = n;
      end
      if (!mode_clk && pm && f1 < 0) f1 = n;
      pm = mode_clk;
      if (load_done) break;
      if (n > PER * (NB + 2)) begin
        check("R4 load never done", 0, 1);
        break;
      end
    end
    check("R2 first rise", 64'(r1), 64'(PER / 2));
    check("R1 period", 64'(r2 - r1), 64'(PER));
    check("R1 high time", 64'(f1 - r1), 64'(PER / 2));
    check("R2 done latency", 64'(n), 64'(PER / 2 + PER * (NB - 1)));
  endtask

  task automatic power_off();
    @(negedge clk);
    power_ok = 1'b0;
    @(negedge clk);
    check("R5 done cleared", 64'(load_done), 0);
    check("R5 word cleared", 64'(mode_word), 0);
    check("R1 mode_clk low", 64'(mode_clk), 0);
    check("R8 err cleared", 64'(cfg_err), 0);
    repeat (20) @(negedge clk);
  endtask

  logic [NB-1:0] wa, wb, wc, wd;

  initial begin
    wa = make_word(40'hA5_3C96_E10F, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1);
    wb = make_word(40'h1E_0F0F_3001, 1'b1, 1'b1, 2'b01, 1'b0, 1'b1);
    wc = make_word(40'hFF_FFFF_FFFF, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1);
    wd = make_word(40'h80_1234_5678, 1'b1, 1'b0, 2'b11, 1'b1, 1'b0);

    repeat (5) @(negedge clk);
    // R9 reset state
    check("R9 mode_clk", 64'(mode_clk), 0);
    check("R9 load_done", 64'(load_done), 0);
    check("R9 mode_word", 64'(mode_word), 0);
    check("R9 outputs", 64'({big_endian, drive_sel, cfg_err}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // load A: pin decides byte order, fast timing, no error
    full_load(wa, 1'b1);
    big_endian_pin = 1'b0;
    @(negedge clk);
    check("R6 pin follow low", 64'(big_endian), 0);
    big_endian_pin = 1'b1;
    @(negedge clk);
    check("R6 pin follow high", 64'(big_endian), 1);
    repeat (3 * PER) @(negedge clk);
    check("R4 word frozen", 64'(mode_word), 64'(wa));
    check("R4 done held", 64'(load_done), 1);
    power_off();

    // load B: stored byte order overrides low pin, slow timing, error
    full_load(wb, 1'b0);
    power_off();

    // abort C part way, then a full load D must still be exact
    rom = wc;
    @(negedge clk);
    power_ok = 1'b1;
    repeat (10 * PER) @(negedge clk);
    check("R4 not done mid-load", 64'(load_done), 0);
    check("R4 word hidden mid-load", 64'(mode_word), 0);
    power_off();
    full_load(wd, 1'b1);

    // R9 asynchronous reset while loaded
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async clear done", 64'(load_done), 0);
    check("R9 async clear word", 64'(mode_word), 0);
    power_ok = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check("R4 scoreboard drained", 64'(exp_q.size()), 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule